// File: doc/BRIEF.md
# DVFS and configuration request engine

This block is the request side of a power controller that serves two processor clusters, one "big" and one "little". Software writes a register to ask for a new performance level on one cluster, or to read a word from the controller's table of operating points. Each accepted request stays busy for a fixed, programmable number of clock cycles. This stands in for the regulator, clock and remote-link delays that the block does not model. When the time is up, the block records the outcome in a status register and raises a level-high interrupt.

Software reads the status register to find out which request finished and how. That read also clears the status. On success, a level request updates the cluster's current-level output. On success, a configuration request leaves the fetched table word in a read-data register.

The register bus takes requests with a valid/ready handshake. Ready is always high, so the block never applies back-pressure. A read is answered exactly one cycle after it is accepted, with read-valid set for one cycle. The response path has no ready, so the bus master must always accept the response.

Top module: `pwr_req_engine`

## Requirements
- R1: After reset, both level outputs are 0, the interrupt is low, and a status read returns 0.
- R2: A write to byte address 0x000 with a value below the big cluster's point count (default 5) is a type-0 request. Exactly LATENCY cycles after the accepting edge, big_level takes that value and status bit 0 is set.
- R3: A write to 0x008 with a value below the little cluster's point count (default 4) is a type-1 request. After LATENCY cycles, little_level takes that value and status bit 4 is set.
- R4: A level write whose value is at or above the cluster's point count sets the error bit after LATENCY cycles: bit 1 for big, bit 5 for little. The level output is left unchanged.
- R5: A write to the command register 0x010 with bit 31 set, function code 6 in bits 23:20 and a word offset in bits 19:0 is a type-2 request. Big point i is at word offset 0x304+i and little point i is at 0x30C+i. On success, status bit 8 is set and register 0x074 returns the table word. Big point i holds voltage 850+50i mV in bits 31:20 and frequency 30000+5000i (20 kHz units) in bits 19:0. Little point i holds 700+50i mV and 20000+5000i.
- R6: A command whose offset falls outside the valid points, or whose function code is not 6, sets status bit 9 after LATENCY cycles, and 0x074 then returns 0.
- R7: A command write with bit 31 clear starts nothing: no status bit is set and the interrupt stays low.
- R8: A request written while another is busy is dropped. The new request's error bit (1, 5 or 9) is set at the accepting edge. The request already in flight still completes normally.
- R9: A status read (0x018) returns the pending bits and clears them, and the interrupt falls. The interrupt is high whenever any status bit is set.
- R10: No completion is reported earlier than LATENCY cycles after acceptance.
- R11: bus_ready is always high. Read data arrives one cycle after acceptance with bus_rvalid. Registers 0x000 and 0x008 read back the current levels. Register 0x070 holds the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request valid |
| bus_ready | output | 1 | Bus request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read response data |
| irq | output | 1 | Level-high interrupt, set while status is non-zero |
| big_level | output | 3 | Current big-cluster performance level |
| little_level | output | 3 | Current little-cluster performance level |

## Verification
The hardest case to reach is a second request that lands while the first is still counting down. It has to flag its own error at once and must not disturb the first request's outcome. The bench writes a big-cluster level and, on the very next cycle, a little-cluster level. It checks that the interrupt is already high before the first request has finished. After the first request completes, it checks that the status read shows both the big completion and the little error, that the big level moved, and that the little level did not. Exact latency is checked by sampling the interrupt one cycle before and one cycle at the expected completion edge.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int MAX_PTS = 8;
  localparam int LVL_W   = $clog2(MAX_PTS);
  localparam int OFF_W   = 20;

  typedef enum logic [1:0] {
    RQ_BIG = 2'd0,
    RQ_LIT = 2'd1,
    RQ_CFG = 2'd2
  } rq_type_e;

  localparam logic [ADDR_W-1:0] A_BIG  = 12'h000;
  localparam logic [ADDR_W-1:0] A_LIT  = 12'h008;
  localparam logic [ADDR_W-1:0] A_CMD  = 12'h010;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h018;
  localparam logic [ADDR_W-1:0] A_WDAT = 12'h070;
  localparam logic [ADDR_W-1:0] A_RDAT = 12'h074;

  localparam logic [3:0]       FUNC_PERF = 4'd6;
  localparam logic [OFF_W-1:0] BIG_WOFF  = 20'h304;
  localparam logic [OFF_W-1:0] LIT_WOFF  = 20'h30C;

  // Operating point word: mV in [31:20], frequency in 20 kHz units in [19:0]
  function automatic logic [DATA_W-1:0] perf_word(input logic little, input int idx);
    int mv;
    int fu;
    mv = (little ? 700 : 850) + 50 * idx;
    fu = (little ? 20000 : 30000) + 5000 * idx;
    return {mv[11:0], fu[19:0]};
  endfunction

  // Status bit for a request type: completion at 4*type, error at 4*type+1
  function automatic logic [DATA_W-1:0] slot_bit(input rq_type_e t, input logic err);
    return 32'd1 << (4 * int'(t) + int'(err));
  endfunction
endpackage

// File: rtl/perf_table.sv
module perf_table
  import pwr_req_pkg::*;
#(
  parameter int NPTS_BIG = 5,
  parameter int NPTS_LIT = 4
) (
  input  logic [OFF_W-1:0]  word_off,
  output logic              hit,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] big_words [MAX_PTS];
  logic [DATA_W-1:0] lit_words [MAX_PTS];

  for (genvar g = 0; g < MAX_PTS; g++) begin : g_pts
    assign big_words[g] = perf_word(1'b0, g);
    assign lit_words[g] = perf_word(1'b1, g);
  end

  logic [OFF_W-1:0] bdiff, ldiff;
  assign bdiff = word_off - BIG_WOFF;
  assign ldiff = word_off - LIT_WOFF;

  always_comb begin
    hit  = 1'b0;
    word = '0;
    if (bdiff < OFF_W'(NPTS_BIG)) begin
      hit  = 1'b1;
      word = big_words[bdiff[LVL_W-1:0]];
    end else if (ldiff < OFF_W'(NPTS_LIT)) begin
      hit  = 1'b1;
      word = lit_words[ldiff[LVL_W-1:0]];
    end
  end
endmodule

// File: rtl/req_timer.sv
module req_timer #(
  parameter int LATENCY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(LATENCY - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/pwr_req_engine.sv
module pwr_req_engine
  import pwr_req_pkg::*;
#(
  parameter int LATENCY  = 16,
  parameter int NPTS_BIG = 5,
  parameter int NPTS_LIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic [LVL_W-1:0]  big_level,
  output logic [LVL_W-1:0]  little_level
);
  logic wr, rd, wr_big, wr_lit, wr_go, start_any, launch, reject;
  logic tmr_busy, tmr_done;
  logic tbl_hit;
  logic [DATA_W-1:0] tbl_word;
  rq_type_e new_type;
  logic new_ok;

  rq_type_e          pend_type;
  logic              pend_err;
  logic [LVL_W-1:0]  pend_lvl;
  logic [DATA_W-1:0] pend_data;

  logic [DATA_W-1:0] status, set_bits, cfg_rdata, wdat_reg;

  assign bus_ready = 1'b1;
  assign wr     = bus_valid && bus_write;
  assign rd     = bus_valid && !bus_write;
  assign wr_big = wr && (bus_addr == A_BIG);
  assign wr_lit = wr && (bus_addr == A_LIT);
  assign wr_go  = wr && (bus_addr == A_CMD) && bus_wdata[31];
  assign start_any = wr_big || wr_lit || wr_go;
  assign launch = start_any && !tmr_busy;
  assign reject = start_any && tmr_busy;

  perf_table #(.NPTS_BIG(NPTS_BIG), .NPTS_LIT(NPTS_LIT)) u_tbl (
    .word_off (bus_wdata[OFF_W-1:0]),
    .hit      (tbl_hit),
    .word     (tbl_word)
  );

  req_timer #(.LATENCY(LATENCY)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (launch),
    .busy  (tmr_busy),
    .done  (tmr_done)
  );

  always_comb begin
    if (wr_big) begin
      new_type = RQ_BIG;
      new_ok   = bus_wdata < DATA_W'(NPTS_BIG);
    end else if (wr_lit) begin
      new_type = RQ_LIT;
      new_ok   = bus_wdata < DATA_W'(NPTS_LIT);
    end else begin
      new_type = RQ_CFG;
      new_ok   = (bus_wdata[23:20] == FUNC_PERF) && tbl_hit;
    end
  end

  always_comb begin
    set_bits = '0;
    if (tmr_done) set_bits = set_bits | slot_bit(pend_type, pend_err);
    if (reject)   set_bits = set_bits | slot_bit(new_type, 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_type    <= RQ_BIG;
      pend_err     <= 1'b0;
      pend_lvl     <= '0;
      pend_data    <= '0;
      status       <= '0;
      cfg_rdata    <= '0;
      wdat_reg     <= '0;
      big_level    <= '0;
      little_level <= '0;
      bus_rvalid   <= 1'b0;
      bus_rdata    <= '0;
    end else begin
      if (launch) begin
        pend_type <= new_type;
        pend_err  <= !new_ok;
        pend_lvl  <= bus_wdata[LVL_W-1:0];
        pend_data <= tbl_word;
      end
      if (tmr_done && !pend_err) begin
        if (pend_type == RQ_BIG) big_level    <= pend_lvl;
        if (pend_type == RQ_LIT) little_level <= pend_lvl;
      end
      if (tmr_done && pend_type == RQ_CFG)
        cfg_rdata <= pend_err ? '0 : pend_data;
      if (wr && bus_addr == A_WDAT) wdat_reg <= bus_wdata;
      status <= ((rd && bus_addr == A_STAT) ? '0 : status) | set_bits;

      bus_rvalid <= rd;
      if (rd) begin
        case (bus_addr)
          A_BIG:   bus_rdata <= DATA_W'(big_level);
          A_LIT:   bus_rdata <= DATA_W'(little_level);
          A_STAT:  bus_rdata <= status;
          A_WDAT:  bus_rdata <= wdat_reg;
          A_RDAT:  bus_rdata <= cfg_rdata;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  assign irq = |status;
endmodule

// File: rtl/pwr_req_checker.sv
module pwr_req_checker #(
  parameter int NPTS_BIG = 5,
  parameter int NPTS_LIT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [11:0] bus_addr,
  input logic        bus_rvalid,
  input logic        irq,
  input logic [2:0]  big_level,
  input logic [2:0]  little_level,
  input logic        tmr_busy,
  input logic        tmr_done
);
  p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_done |=> $stable(big_level));

  p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_done |=> $stable(little_level));

  p_level_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(big_level) < NPTS_BIG) && (32'(little_level) < NPTS_LIT));

  p_reject_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && tmr_busy && (bus_addr == 12'h000 || bus_addr == 12'h008))
    |=> irq);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_valid && !bus_write && bus_addr == 12'h018));

  p_rsp_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_write));
endmodule

bind pwr_req_engine pwr_req_checker #(.NPTS_BIG(NPTS_BIG), .NPTS_LIT(NPTS_LIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_rvalid   (bus_rvalid),
  .irq          (irq),
  .big_level    (big_level),
  .little_level (little_level),
  .tmr_busy     (tmr_busy),
  .tmr_done     (tmr_done)
);

// File: tb/tb_pwr_req_engine.sv
`timescale 1ns/1ps
module tb_pwr_req_engine;
  localparam int LAT = 12;
  localparam int NB  = 5;
  localparam int NL  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [2:0]  big_level, little_level;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  pwr_req_engine #(.LATENCY(LAT), .NPTS_BIG(NB), .NPTS_LIT(NL)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq(irq),
    .big_level(big_level), .little_level(little_level)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tbl(input bit little, input int i);
    int mv, fu;
    mv = little ? 700 + 50 * i : 850 + 50 * i;
    fu = little ? 20000 + 5000 * i : 30000 + 5000 * i;
    return (32'(mv) << 20) | 32'(fu);
  endfunction

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected response", bus_rdata, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    check(bus_ready === 1'b1, "R11 ready", 32'(bus_ready), 32'h1);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wait_lat();
    repeat (LAT) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(irq === 1'b0, "R1 irq", 32'(irq), 0);
    check(big_level === 3'd0, "R1 big_level", 32'(big_level), 0);
    check(little_level === 3'd0, "R1 little_level", 32'(little_level), 0);
    bus_rd(12'h018, 32'h0, "R1 status");

    // R2 + R10 exact latency
    bus_wr(12'h000, 32'd3);
    repeat (LAT - 1) @(negedge clk);
    check(irq === 1'b0, "R10 early irq", 32'(irq), 0);
    check(big_level === 3'd0, "R10 early level", 32'(big_level), 0);
    @(negedge clk);
    check(irq === 1'b1, "R2 irq", 32'(irq), 1);
    check(big_level === 3'd3, "R2 big_level", 32'(big_level), 3);
    bus_rd(12'h018, 32'h1, "R2 status");
    check(irq === 1'b0, "R9 irq cleared", 32'(irq), 0);
    bus_rd(12'h018, 32'h0, "R9 status cleared");

    // R3
    bus_wr(12'h008, 32'd2);
    wait_lat();
    check(little_level === 3'd2, "R3 little_level", 32'(little_level), 2);
    bus_rd(12'h018, 32'h10, "R3 status");

    // R4 invalid levels (boundary: equal to count)
    bus_wr(12'h000, 32'd5);
    wait_lat();
    check(big_level === 3'd3, "R4 big unchanged", 32'(big_level), 3);
    bus_rd(12'h018, 32'h2, "R4 big error");
    bus_wr(12'h008, 32'd7);
    wait_lat();
    check(little_level === 3'd2, "R4 little unchanged", 32'(little_level), 2);
    bus_rd(12'h018, 32'h20, "R4 little error");

    // R5 valid config reads
    bus_wr(12'h010, 32'h8000_0000 | (32'd6 << 20) | 32'h306);
    wait_lat();
    bus_rd(12'h018, 32'h100, "R5 status big pt2");
    bus_rd(12'h074, tbl(1'b0, 2), "R5 data big pt2");
    bus_wr(12'h010, 32'h8000_0000 | (32'd6 << 20) | 32'h30F);
    wait_lat();
    bus_rd(12'h018, 32'h100, "R5 status little pt3");
    bus_rd(12'h074, tbl(1'b1, 3), "R5 data little pt3");
    bus_wr(12'h010, 32'h8000_0000 | (32'd6 << 20) | 32'h304);
    wait_lat();
    bus_rd(12'h018, 32'h100, "R5 status big pt0");
    bus_rd(12'h074, tbl(1'b0, 0), "R5 data big pt0");

    // R6 out of table / wrong function
    bus_wr(12'h010, 32'h8000_0000 | (32'd6 << 20) | 32'h309);
    wait_lat();
    bus_rd(12'h018, 32'h200, "R6 status offset");
    bus_rd(12'h074, 32'h0, "R6 data offset");
    bus_wr(12'h010, 32'h8000_0000 | (32'd6 << 20) | 32'h30C);
    wait_lat();
    bus_rd(12'h074, tbl(1'b1, 0), "R5 data little pt0");
    bus_rd(12'h018, 32'h100, "R5 status little pt0");
    bus_wr(12'h010, 32'h8000_0000 | (32'd5 << 20) | 32'h304);
    wait_lat();
    bus_rd(12'h018, 32'h200, "R6 status function");
    bus_rd(12'h074, 32'h0, "R6 data function");

    // R7 no start bit
    bus_wr(12'h010, (32'd6 << 20) | 32'h304);
    repeat (LAT + 2) @(negedge clk);
    check(irq === 1'b0, "R7 irq", 32'(irq), 0);
    bus_rd(12'h018, 32'h0, "R7 status");

    // R8 request while busy
    bus_wr(12'h000, 32'd1);
    bus_wr(12'h008, 32'd0);
    check(irq === 1'b1, "R8 immediate error irq", 32'(irq), 1);
    wait_lat();
    check(big_level === 3'd1, "R8 first completes", 32'(big_level), 1);
    check(little_level === 3'd2, "R8 dropped level", 32'(little_level), 2);
    bus_rd(12'h018, 32'h21, "R8 status");

    // R8 busy config request error slot
    bus_wr(12'h008, 32'd1);
    bus_wr(12'h010, 32'h8000_0000 | (32'd6 << 20) | 32'h304);
    wait_lat();
    bus_rd(12'h018, 32'h210, "R8 cfg reject status");

    // R11 register readback
    bus_wr(12'h070, 32'hCAFE_0123);
    bus_rd(12'h070, 32'hCAFE_0123, "R11 wdata reg");
    bus_rd(12'h000, 32'd1, "R11 big readback");
    bus_rd(12'h008, 32'd1, "R11 little readback");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R11 all responses seen", 32'(exp_q.size()), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule